// File: doc/BRIEF.md
# Register Rename Map with Ordered History Rollback

This block keeps the mapping from architectural registers to physical registers for an out-of-order core. Each rename request for a destination takes the lowest-numbered free physical register, points the architectural register at it, clears that register's ready bit, and appends a log record holding the instruction sequence number, the architectural register, the new physical register and the physical register that was mapped before. Source operands are looked up combinationally. A second combinational port reads the ready bit of any physical register. Writeback sets ready bits.

Retirement and recovery both work on the log, one record per cycle. A commit to sequence number S pops records from the oldest end while their number is at most S, and returns each record's previous register to the free list. A squash after sequence number S pops records from the newest end while their number is greater than S. Each popped record restores the map entry to its previous register and returns the new register to the free list. Squash also marks returned registers in the special range (index at or above `NUM_REGULAR`) as ready. While a walk is in progress `busy` is high and renaming is stalled.

A three-state machine runs the walks. `ST_IDLE` accepts requests. It moves to `ST_SQUASH` on `sq_valid`, or else to `ST_COMMIT` on `cmt_valid`. `ST_COMMIT` stays put while the oldest record qualifies and pops it, then returns to `ST_IDLE` in the first cycle in which no record qualifies. `ST_SQUASH` behaves the same way on the newest record and returns to `ST_IDLE` when no record qualifies.

Top module: `rename_map_rollback`

## Requirements
- R1: After reset, architectural register i maps to physical register i and every ready bit is 1. Physical registers `NUM_ARCH` to `NUM_PHYS-1` are free, and the lowest index is allocated first.
- R2: A rename fires on a rising edge where `rn_valid` is 1 and `rn_stall` is 0. In that cycle `rn_preg` shows the lowest-numbered free register and `rn_prev` shows the current mapping of `rn_areg`. After the edge, `rn_areg` maps to `rn_preg` and that register's ready bit is 0.
- R3: `src_preg`/`src_ready` follow `src_areg` in the same cycle, and `rdy_q` follows `rdy_qidx` in the same cycle, with no clock edge in between.
- R4: A `wb_valid` pulse sets the ready bit of `wb_preg` from the next cycle on.
- R5: `rn_stall` is 1 when the free list is empty, when the history is full, or when `busy` is 1. A stalled request leaves the map, the ready bits and the free list unchanged.
- R6: A commit removes records oldest-first while their sequence number is ≤ `cmt_seq`, and frees each record's previous register.
- R7: A squash removes records newest-first while their sequence number is > `sq_seq`. Each removal restores the map entry to its previous register and frees its new register.
- R8: When a squash frees a register with index ≥ `NUM_REGULAR`, that register's ready bit becomes 1. A register below that index keeps its ready bit.
- R9: A commit whose oldest record is already younger than `cmt_seq`, or a squash on an empty history, changes nothing and holds `busy` for exactly one cycle.
- R10: `busy` rises on the edge that accepts a walk and stays high for N+1 cycles, where N is the number of records removed. `cmt_valid` and `sq_valid` are ignored while `busy` is 1. If both are 1 in `ST_IDLE`, the squash is taken and the commit is dropped.
- R11: Registers returned by a commit or a squash can be allocated again, still lowest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | Rename request for one destination |
| rn_areg | input | AW | Destination architectural register |
| rn_seq | input | SEQ_W | Sequence number of the renaming instruction |
| rn_stall | output | 1 | Rename cannot be accepted this cycle |
| rn_preg | output | PW | Physical register that will be assigned |
| rn_prev | output | PW | Physical register currently mapped to `rn_areg` |
| src_areg | input | AW | Source architectural register to look up |
| src_preg | output | PW | Mapped physical register of the source |
| src_ready | output | 1 | Ready bit of `src_preg` |
| rdy_qidx | input | PW | Physical register whose ready bit is queried |
| rdy_q | output | 1 | Ready bit of `rdy_qidx` |
| wb_valid | input | 1 | Writeback completes |
| wb_preg | input | PW | Physical register written back |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| busy | output | 1 | A commit or squash walk is in progress |

## Verification
The assertions assume the usual pipeline contract. Sequence numbers are pushed in rising order and do not wrap. A register is never freed twice. Writeback names only registers that are currently allocated. If these hold, a double free or a pop from an empty log can only come from a fault in the walk logic. The stimulus keeps to this contract because a counter gives every rename a fresh, larger sequence number. Writeback targets are drawn from the bench's own free-list model, and squash and commit points are derived from the bench's own copy of the log, so every walk stops on a real record boundary or on an empty log.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_SQUASH = 2'd2
    } walk_state_t;
endpackage

// File: rtl/rmap_freelist.sv
module rmap_freelist #(
    parameter int NUM_PHYS = 16,
    parameter int NUM_ARCH = 8,
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic          free_en,
    input  logic [PW-1:0] free_idx,
    output logic [PW-1:0] alloc_idx,
    output logic          avail
);
    logic [NUM_PHYS-1:0] pool_q;

    always_comb begin
        alloc_idx = '0;
        for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (pool_q[i]) alloc_idx = PW'(i);
        end
    end

    assign avail = |pool_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) pool_q[i] <= (i >= NUM_ARCH);
        end else begin
            if (alloc_en) pool_q[alloc_idx] <= 1'b0;
            if (free_en)  pool_q[free_idx]  <= 1'b1;
        end
    end

    AST_NO_DOUBLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> !pool_q[free_idx]);          // R6
    AST_ALLOC_ONLY_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> avail);                     // R5
endmodule

// File: rtl/rmap_history.sv
module rmap_history #(
    parameter int DEPTH = 16,
    parameter int SEQ_W = 16,
    parameter int AW    = 3,
    parameter int PW    = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [SEQ_W-1:0] push_seq,
    input  logic [AW-1:0]    push_areg,
    input  logic [PW-1:0]    push_new,
    input  logic [PW-1:0]    push_prev,
    input  logic             pop_newest,
    input  logic             pop_oldest,
    output logic             empty,
    output logic             full,
    output logic [SEQ_W-1:0] newest_seq,
    output logic [AW-1:0]    newest_areg,
    output logic [PW-1:0]    newest_new,
    output logic [PW-1:0]    newest_prev,
    output logic [SEQ_W-1:0] oldest_seq,
    output logic [PW-1:0]    oldest_prev
);
    logic [SEQ_W-1:0] seq_mem  [DEPTH];
    logic [AW-1:0]    areg_mem [DEPTH];
    logic [PW-1:0]    new_mem  [DEPTH];
    logic [PW-1:0]    prev_mem [DEPTH];
    logic [IW:0]      head_q, tail_q;
    logic [IW-1:0]    top_idx, bot_idx;

    assign top_idx = head_q[IW-1:0] - IW'(1);
    assign bot_idx = tail_q[IW-1:0];
    assign empty   = (head_q == tail_q);
    assign full    = (head_q[IW] != tail_q[IW]) && (head_q[IW-1:0] == tail_q[IW-1:0]);

    assign newest_seq  = seq_mem[top_idx];
    assign newest_areg = areg_mem[top_idx];
    assign newest_new  = new_mem[top_idx];
    assign newest_prev = prev_mem[top_idx];
    assign oldest_seq  = seq_mem[bot_idx];
    assign oldest_prev = prev_mem[bot_idx];

    always_ff @(posedge clk) begin
        if (push) begin
            seq_mem[head_q[IW-1:0]]  <= push_seq;
            areg_mem[head_q[IW-1:0]] <= push_areg;
            new_mem[head_q[IW-1:0]]  <= push_new;
            prev_mem[head_q[IW-1:0]] <= push_prev;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push)       head_q <= head_q + 1'b1;
            if (pop_newest) head_q <= head_q - 1'b1;
            if (pop_oldest) tail_q <= tail_q + 1'b1;
        end
    end

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);                                         // R5
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_newest || pop_oldest) |-> !empty);                  // R9
    AST_ONE_LOG_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({push, pop_newest, pop_oldest}) <= 1);        // R10
endmodule

// File: rtl/rmap_scoreboard.sv
module rmap_scoreboard #(
    parameter int NUM_PHYS = 16,
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_a_en,
    input  logic [PW-1:0]       set_a_idx,
    input  logic                set_b_en,
    input  logic [PW-1:0]       set_b_idx,
    input  logic                clr_en,
    input  logic [PW-1:0]       clr_idx,
    input  logic [PW-1:0]       qa_idx,
    input  logic [PW-1:0]       qb_idx,
    output logic                qa,
    output logic                qb,
    output logic [NUM_PHYS-1:0] ready_vec
);
    logic [NUM_PHYS-1:0] rdy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= '1;
        end else begin
            if (set_a_en) rdy_q[set_a_idx] <= 1'b1;
            if (set_b_en) rdy_q[set_b_idx] <= 1'b1;
            if (clr_en)   rdy_q[clr_idx]   <= 1'b0;
        end
    end

    assign qa        = rdy_q[qa_idx];
    assign qb        = rdy_q[qb_idx];
    assign ready_vec = rdy_q;
endmodule

// File: rtl/rename_map_rollback.sv
module rename_map_rollback
    import rmap_pkg::*;
#(
    parameter int NUM_ARCH    = 8,
    parameter int NUM_PHYS    = 16,
    parameter int NUM_REGULAR = 14,
    parameter int HIST_DEPTH  = 16,
    parameter int SEQ_W       = 16,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rn_valid,
    input  logic [AW-1:0]    rn_areg,
    input  logic [SEQ_W-1:0] rn_seq,
    output logic             rn_stall,
    output logic [PW-1:0]    rn_preg,
    output logic [PW-1:0]    rn_prev,
    input  logic [AW-1:0]    src_areg,
    output logic [PW-1:0]    src_preg,
    output logic             src_ready,
    input  logic [PW-1:0]    rdy_qidx,
    output logic             rdy_q,
    input  logic             wb_valid,
    input  logic [PW-1:0]    wb_preg,
    input  logic             cmt_valid,
    input  logic [SEQ_W-1:0] cmt_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             busy
);
    walk_state_t      state_q, state_d;
    logic [SEQ_W-1:0] limit_q;
    logic [PW-1:0]    map_q [NUM_ARCH];

    logic             fl_avail;
    logic [PW-1:0]    fl_alloc;
    logic             fl_free_en;
    logic [PW-1:0]    fl_free_idx;
    logic             h_empty, h_full;
    logic [SEQ_W-1:0] h_new_seq, h_old_seq;
    logic [AW-1:0]    h_new_areg;
    logic [PW-1:0]    h_new_new, h_new_prev, h_old_prev;
    logic             rn_fire, commit_step, squash_step, special_ret;
    logic [NUM_PHYS-1:0] ready_vec;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (state_q == ST_IDLE) begin
            if (sq_valid)       limit_q <= sq_seq;
            else if (cmt_valid) limit_q <= cmt_seq;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sq_valid)       state_d = ST_SQUASH;
                else if (cmt_valid) state_d = ST_COMMIT;
            end
            ST_COMMIT: if (!commit_step) state_d = ST_IDLE;
            ST_SQUASH: if (!squash_step) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the walk machine
    always_comb begin
        busy        = (state_q != ST_IDLE);
        commit_step = 1'b0;
        squash_step = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COMMIT: commit_step = !h_empty && (h_old_seq <= limit_q);
            ST_SQUASH: squash_step = !h_empty && (h_new_seq > limit_q);
            default:   ;
        endcase
    end

    assign rn_stall    = busy || !fl_avail || h_full;
    assign rn_fire     = rn_valid && !rn_stall;
    assign rn_preg     = fl_alloc;
    assign rn_prev     = map_q[rn_areg];
    assign src_preg    = map_q[src_areg];
    assign fl_free_en  = commit_step || squash_step;
    assign fl_free_idx = commit_step ? h_old_prev : h_new_new;
    assign special_ret = squash_step && (32'(h_new_new) >= NUM_REGULAR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
        end else if (rn_fire) begin
            map_q[rn_areg] <= fl_alloc;
        end else if (squash_step) begin
            map_q[h_new_areg] <= h_new_prev;
        end
    end

    rmap_freelist #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH)) u_free (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(rn_fire), .free_en(fl_free_en), .free_idx(fl_free_idx),
        .alloc_idx(fl_alloc), .avail(fl_avail)
    );

    rmap_history #(.DEPTH(HIST_DEPTH), .SEQ_W(SEQ_W), .AW(AW), .PW(PW)) u_log (
        .clk(clk), .rst_n(rst_n),
        .push(rn_fire), .push_seq(rn_seq), .push_areg(rn_areg),
        .push_new(fl_alloc), .push_prev(rn_prev),
        .pop_newest(squash_step), .pop_oldest(commit_step),
        .empty(h_empty), .full(h_full),
        .newest_seq(h_new_seq), .newest_areg(h_new_areg),
        .newest_new(h_new_new), .newest_prev(h_new_prev),
        .oldest_seq(h_old_seq), .oldest_prev(h_old_prev)
    );

    rmap_scoreboard #(.NUM_PHYS(NUM_PHYS)) u_sb (
        .clk(clk), .rst_n(rst_n),
        .set_a_en(wb_valid), .set_a_idx(wb_preg),
        .set_b_en(special_ret), .set_b_idx(h_new_new),
        .clr_en(rn_fire), .clr_idx(fl_alloc),
        .qa_idx(src_preg), .qb_idx(rdy_qidx),
        .qa(src_ready), .qb(rdy_q), .ready_vec(ready_vec)
    );

    AST_BUSY_BLOCKS_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rn_stall);                                                    // R10
    AST_RENAME_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rn_fire |=> !ready_vec[$past(rn_preg)]);                               // R2
    AST_RENAME_UPDATES_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        rn_fire |=> (map_q[$past(rn_areg)] == $past(rn_preg)));                // R2
    AST_COMMIT_STOPS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(state_q == ST_COMMIT)) |-> (h_empty || h_old_seq > limit_q)); // R6
    AST_SQUASH_STOPS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(state_q == ST_SQUASH)) |-> (h_empty || h_new_seq <= limit_q)); // R7
    AST_SPECIAL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        special_ret |=> ready_vec[$past(h_new_new)]);                          // R8
endmodule

// File: tb/tb_rename_map_rollback.sv
module tb_rename_map_rollback;
    localparam int NA = 8, NP = 16, NREG = 14, HD = 16, SW = 16;
    localparam int AW = $clog2(NA), PW = $clog2(NP);

    logic clk = 0, rst_n = 0;
    logic rn_valid = 0, rn_stall;
    logic [AW-1:0] rn_areg = '0, src_areg = '0;
    logic [SW-1:0] rn_seq = '0, cmt_seq = '0, sq_seq = '0;
    logic [PW-1:0] rn_preg, rn_prev, src_preg, rdy_qidx = '0, wb_preg = '0;
    logic src_ready, rdy_q, wb_valid = 0, cmt_valid = 0, sq_valid = 0, busy;

    always #4 clk = ~clk;

    rename_map_rollback #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_REGULAR(NREG),
                          .HIST_DEPTH(HD), .SEQ_W(SW)) dut (.*);

    int n_chk = 0, n_fail = 0, nseq = 1;
    bit done = 0;
    int m_map [NA];
    bit m_free [NP], m_ready [NP];
    int h_seq [HD], h_areg [HD], h_new [HD], h_prev [HD];
    int hcnt = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int low_free();
        for (int p = 0; p < NP; p++) if (m_free[p]) return p;
        return -1;
    endfunction

    task automatic check_all(string req);
        for (int a = 0; a < NA; a++) begin
            src_areg = AW'(a); #1;
            chk(req, "src_preg", int'(src_preg), m_map[a]);
            chk(req, "src_ready", int'(src_ready), int'(m_ready[m_map[a]]));
        end
        for (int p = 0; p < NP; p++) begin
            rdy_qidx = PW'(p); #1;
            chk(req, "rdy_q", int'(rdy_q), int'(m_ready[p]));
        end
    endtask

    task automatic do_rename(int a);
        int lf;
        @(negedge clk);
        rn_valid = 1; rn_areg = AW'(a); rn_seq = SW'(nseq); #1;
        lf = low_free();
        chk("R5", "rn_stall", int'(rn_stall), int'(lf < 0));
        if (lf >= 0) begin
            chk("R2", "rn_preg", int'(rn_preg), lf);
            chk("R2", "rn_prev", int'(rn_prev), m_map[a]);
        end
        @(posedge clk); #1;
        rn_valid = 0;
        if (lf >= 0) begin
            h_seq[hcnt] = nseq; h_areg[hcnt] = a; h_new[hcnt] = lf; h_prev[hcnt] = m_map[a];
            hcnt++;
            m_free[lf] = 0; m_ready[lf] = 0; m_map[a] = lf;
            nseq++;
        end
    endtask

    task automatic do_wb(int p);
        @(negedge clk);
        wb_valid = 1; wb_preg = PW'(p);
        @(posedge clk); #1;
        wb_valid = 0;
        m_ready[p] = 1;
    endtask

    // kind 0 = commit, 1 = squash, 2 = squash and commit together
    task automatic do_walk(int kind, int s, bit hold_cmt, string req);
        int n = 0, cyc = 0;
        @(negedge clk);
        if (kind == 0) begin cmt_valid = 1; cmt_seq = SW'(s); end
        else begin sq_valid = 1; sq_seq = SW'(s); end
        if (kind == 2) begin cmt_valid = 1; cmt_seq = '1; end
        @(posedge clk); #1;
        sq_valid = 0; cmt_valid = hold_cmt;
        if (hold_cmt) cmt_seq = '1;
        if (kind == 0) begin
            while (hcnt > 0 && h_seq[0] <= s) begin
                m_free[h_prev[0]] = 1;
                for (int i = 0; i < hcnt - 1; i++) begin
                    h_seq[i] = h_seq[i+1]; h_areg[i] = h_areg[i+1];
                    h_new[i] = h_new[i+1]; h_prev[i] = h_prev[i+1];
                end
                hcnt--; n++;
            end
        end else begin
            while (hcnt > 0 && h_seq[hcnt-1] > s) begin
                m_map[h_areg[hcnt-1]] = h_prev[hcnt-1];
                m_free[h_new[hcnt-1]] = 1;
                if (h_new[hcnt-1] >= NREG) m_ready[h_new[hcnt-1]] = 1;
                hcnt--; n++;
            end
        end
        forever begin
            @(negedge clk);
            if (!busy || cyc > 64) break;
            cyc++;
        end
        cmt_valid = 0;
        chk(req, "busy cycles", cyc, n + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog expired: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int r;
        r = 12345;
        for (int a = 0; a < NA; a++) m_map[a] = a;
        for (int p = 0; p < NP; p++) begin m_free[p] = (p >= NA); m_ready[p] = 1; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);
        check_all("R1 R3");
        // fill the free list: allocations 8..15 in order, then a stall
        for (int a = 0; a < NA; a++) do_rename(a);
        do_rename(3);
        check_all("R5 R2");
        do_wb(9);
        check_all("R4");
        do_walk(0, 3, 0, "R6");
        check_all("R6");
        do_rename(0);                       // reuses register 0
        check_all("R11");
        do_rename(5);
        do_walk(1, 6, 1, "R10");            // commit held high is ignored
        check_all("R7 R8");
        do_walk(0, 0, 0, "R9");             // oldest record is younger
        do_walk(1, 1000, 0, "R9");          // nothing younger
        do_rename(2);
        do_walk(2, 5, 0, "R10");            // squash wins over commit
        check_all("R10");
        do_walk(1, 0, 0, "R7");
        do_walk(1, 0, 0, "R9");             // empty history
        check_all("R7 R11");
        // pseudo-random sweep
        for (int it = 0; it < 400; it++) begin
            int op;
            r = (r * 1103515245 + 12345) & 32'h7fffffff;
            op = (r >> 8) % 8;
            if (op < 4) do_rename((r >> 12) % NA);
            else if (op == 4) begin
                for (int p = 0; p < NP; p++)
                    if (!m_free[p] && !m_ready[p]) begin do_wb(p); break; end
            end else if (op == 5)
                do_walk(0, hcnt > 0 ? h_seq[0] + (r >> 14) % 4 : nseq, 0, "R6");
            else if (op == 6)
                do_walk(1, hcnt > 0 ? h_seq[hcnt-1] - 1 - (r >> 14) % 3 : nseq, 0, "R7");
            else check_all("R2 R8");
        end
        check_all("R11");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule